// File: doc/BRIEF.md
# Multi-line terminal IOT controller

This block serves a bank of up to sixteen character terminal lines from the I/O-transfer (IOT) instruction bus of a 12-bit minicomputer. Each IOT carries a device number and a pulse code. The block looks the device number up in a fixed table of input/output device pairs. The table position gives the line and the direction. The block then acts on that line's flags and buffers. It answers with a skip request, a replacement accumulator value and an error indication, and it drives two summary interrupt requests: one for receive and one for transmit.

Each line has its own input-done flag, output-done flag, interrupt enable, receive buffer and transmit buffer. The enable is shared by both directions of the line. Received characters arrive on a per-line valid/ready port. Transmitted characters leave on a per-line valid/ready port. After the sink accepts a character, a programmable delay stands in for the time the character takes to go out on the wire. The number of lines in service is an input, and lines that leave or join service are cleared.

Top module: `mtio_ctrl`

## Requirements
- R1: The device number is `iot_code[8:3]` and the pulse code is `iot_code[2:0]`. Table slots 2k and 2k+1 hold the input and output device of line k. In line order the pairs are 040/041, 042/043, 044/045, 046/047, 034/035, 011/012, 030/031, 032/033, 050/051, 052/053, 054/055, 056/057, 070/071, 036/037, 072/073 and 006/007 (octal), so line 15 answers to 006/007.
- R2: Only the first 2×`line_count` slots are searched. A device number with no match raises `iot_nomatch`, returns `iot_ac` unchanged, gives no skip and changes no state.
- R3: Input pulses behave as follows. Pulse 0 clears input-done. Pulse 1 skips when input-done is set. Pulse 2 clears input-done and returns 0. Pulse 6 clears input-done and returns the receive byte in bits [7:0], with bits [11:8] zero.
- R4: Input pulse 5 writes `iot_ac[0]` into the line's single enable. Output pulse 5 skips when the enable is set and either done flag of the line is set.
- R5: Output pulse 0 sets output-done. Output pulse 1 skips when output-done is set. Output pulse 2 clears output-done.
- R6: Output pulse 6 clears output-done and starts a transmit. Output pulse 4 starts a transmit and leaves output-done unchanged. A started transmit holds `tx_valid` with `iot_ac[7:0]` on the line's `tx_data` byte until `tx_ready`. Output-done is set at the (D+1)-th clock edge after that handshake edge, where D is `tx_delay`.
- R7: `rx_ready` is high only while the line is in service and its input-done flag is clear. An accepted character is stored and sets input-done. If `rx_break` is set, the value 0 is stored instead.
- R8: `irq_in` is the OR over lines of (input-done AND enable). `irq_out` is the OR over lines of (output-done AND enable).
- R9: Reset clears both done flags and both buffers of every line, sets every enable and cancels any transmit.
- R10: A line that leaves or joins service, because `line_count` changed, is cleared as in R9 at the next edge. While it is out of service it answers no IOT and shows no `rx_ready` or `tx_valid`.
- R11: On a matched device, input pulses 3, 4 and 7 and output pulses 3 and 7 raise `iot_illegal`, return `iot_ac` unchanged and change no state.
- R12: Skip, returned AC and error outputs are combinational while `iot_valid` is high and idle otherwise. Flag changes appear at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_count | input | 5 | Lines in service, 1 to 16 |
| tx_delay | input | 8 | Cycles of simulated send time after handshake |
| iot_valid | input | 1 | IOT strobe |
| iot_code | input | 9 | Device number [8:3] and pulse code [2:0] |
| iot_ac | input | 12 | Accumulator value presented with the IOT |
| iot_skip | output | 1 | Skip request |
| iot_ac_out | output | 12 | Accumulator value returned |
| iot_nomatch | output | 1 | Device number not claimed |
| iot_illegal | output | 1 | Pulse code not defined for the direction |
| irq_in | output | 1 | Summary receive interrupt |
| irq_out | output | 1 | Summary transmit interrupt |
| rx_valid | input | 16 | Per-line receive character present |
| rx_data | input | 128 | Per-line receive byte, line k at [8k+7:8k] |
| rx_break | input | 16 | Per-line break marker for the presented character |
| rx_ready | output | 16 | Per-line receive acceptance |
| tx_valid | output | 16 | Per-line transmit character present |
| tx_data | output | 128 | Per-line transmit byte, line k at [8k+7:8k] |
| tx_ready | input | 16 | Per-line transmit acceptance |

## Verification
The assertions assume that `line_count` stays between 1 and 16. They also assume that `line_count` does not change in the same cycle as an IOT addressed to a line joining or leaving service, and that `tx_delay` is steady while a transmit is counting. The stimulus changes the line count only in idle cycles and waits a cycle before addressing lines whose status changed. It also holds the delay at one value during each transmit. Apart from that, the sources and sinks handshake freely, because the reference model in the bench follows the same acceptance rules.

// File: rtl/mtio_pkg.sv
// Shared types and the device-number table for the multi-line terminal
// controller. Assumes at most 16 lines (32 table slots).
package mtio_pkg;

    localparam int AW       = 12;  // accumulator width
    localparam int SLOT_MAX = 32;  // table slots available

    // Per-line action requested by one IOT
    typedef struct packed {
        logic clr_in;
        logic wr_en;
        logic en_val;
        logic set_out;
        logic clr_out;
        logic start_tx;
    } line_op_t;

    // Device number held in table slot k (even: input, odd: output)
    function automatic logic [5:0] slot_dev(input int unsigned k);
        logic [5:0] lo;
        case (k / 2)
            0:  lo = 6'o40;
            1:  lo = 6'o42;
            2:  lo = 6'o44;
            3:  lo = 6'o46;
            4:  lo = 6'o34;
            5:  lo = 6'o11;
            6:  lo = 6'o30;
            7:  lo = 6'o32;
            8:  lo = 6'o50;
            9:  lo = 6'o52;
            10: lo = 6'o54;
            11: lo = 6'o56;
            12: lo = 6'o70;
            13: lo = 6'o36;
            14: lo = 6'o72;
            15: lo = 6'o06;
            default: lo = 6'o00;
        endcase
        return lo + 6'((k % 2) != 0 ? 1 : 0);
    endfunction

endpackage

// File: rtl/mtio_decode.sv
// Device-number lookup: searches the first 2*count slots of the pair table
// and returns line index and direction. Assumes count <= MAXL <= 16.
module mtio_decode #(
    parameter int MAXL = 16,
    parameter int LW   = 4,
    parameter int CW   = 5
) (
    input  logic [5:0]    dev,
    input  logic [CW-1:0] count,
    output logic          hit,
    output logic [LW-1:0] line,
    output logic          is_out
);
    import mtio_pkg::*;

    localparam int SLOTS = 2 * MAXL;

    // Priority search, lowest slot wins
    always_comb begin
        hit    = 1'b0;
        line   = '0;
        is_out = 1'b0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (k < 2 * int'(count) && slot_dev(unsigned'(k)) == dev) begin
                hit    = 1'b1;
                line   = LW'(k / 2);
                is_out = (k % 2) == 1;
            end
        end
    end

endmodule

// File: rtl/mtio_respond.sv
// Pulse interpreter: turns a decoded IOT into bus responses and one
// line_op_t for the addressed line. Purely combinational.
module mtio_respond #(
    parameter int BW = 8
) (
    input  logic                  valid,
    input  logic                  hit,
    input  logic                  is_out,
    input  logic [2:0]            pulse,
    input  logic [mtio_pkg::AW-1:0] ac,
    input  logic                  sel_idone,
    input  logic                  sel_odone,
    input  logic                  sel_en,
    input  logic [BW-1:0]         sel_rbuf,
    output logic                  skip,
    output logic [mtio_pkg::AW-1:0] ac_out,
    output logic                  nomatch,
    output logic                  illegal,
    output mtio_pkg::line_op_t    op
);
    import mtio_pkg::*;

    // Response and action selection by direction and pulse code
    always_comb begin
        skip    = 1'b0;
        ac_out  = ac;
        nomatch = 1'b0;
        illegal = 1'b0;
        op      = '0;
        if (valid) begin
            if (!hit) begin
                nomatch = 1'b1;
            end else if (!is_out) begin
                case (pulse)
                    3'd0: op.clr_in = 1'b1;
                    3'd1: skip = sel_idone;
                    3'd2: begin
                        op.clr_in = 1'b1;
                        ac_out    = '0;
                    end
                    3'd5: begin
                        op.wr_en  = 1'b1;
                        op.en_val = ac[0];
                    end
                    3'd6: begin
                        op.clr_in = 1'b1;
                        ac_out    = AW'(sel_rbuf);
                    end
                    default: illegal = 1'b1;
                endcase
            end else begin
                case (pulse)
                    3'd0: op.set_out = 1'b1;
                    3'd1: skip = sel_odone;
                    3'd2: op.clr_out = 1'b1;
                    3'd4: op.start_tx = 1'b1;
                    3'd5: skip = sel_en & (sel_idone | sel_odone);
                    3'd6: begin
                        op.clr_out  = 1'b1;
                        op.start_tx = 1'b1;
                    end
                    default: illegal = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/mtio_line.sv
// One terminal line: done flags, enable, buffers and the transmit
// handshake plus delay counter. wipe clears the line synchronously;
// live gates both character ports.
module mtio_line #(
    parameter int BW    = 8,
    parameter int DLY_W = 8
) (
    input  logic               clk,
    input  logic               wipe,
    input  logic               live,
    input  mtio_pkg::line_op_t op,
    input  logic [BW-1:0]      ac_byte,
    input  logic               rx_valid,
    input  logic [BW-1:0]      rx_data,
    input  logic               rx_break,
    output logic               rx_ready,
    output logic               tx_valid,
    output logic [BW-1:0]      tx_data,
    input  logic               tx_ready,
    input  logic [DLY_W-1:0]   tx_delay,
    output logic               idone,
    output logic               odone,
    output logic               en,
    output logic [BW-1:0]      rbuf
);
    logic             pend;
    logic             busy;
    logic [DLY_W-1:0] cnt;
    logic [BW-1:0]    obuf;
    logic             accept;
    logic             sent;
    logic             idone_nx;
    logic             odone_nx;

    assign rx_ready = live & ~idone;
    assign tx_valid = live & pend;
    assign tx_data  = obuf;
    assign accept   = rx_valid & rx_ready;
    assign sent     = busy & (cnt == '0) & ~op.start_tx;

    // Next done flags: clears first, sets win
    always_comb begin
        idone_nx = idone;
        if (op.clr_in) idone_nx = 1'b0;
        if (accept)    idone_nx = 1'b1;
        odone_nx = odone;
        if (op.clr_out)           odone_nx = 1'b0;
        if (op.set_out || sent)   odone_nx = 1'b1;
    end

    // Line state registers with synchronous clear
    always_ff @(posedge clk) begin
        if (wipe) begin
            idone <= 1'b0;
            odone <= 1'b0;
            en    <= 1'b1;
            rbuf  <= '0;
            obuf  <= '0;
            pend  <= 1'b0;
            busy  <= 1'b0;
            cnt   <= '0;
        end else begin
            idone <= idone_nx;
            odone <= odone_nx;
            if (op.wr_en) en <= op.en_val;
            if (accept) rbuf <= rx_break ? '0 : rx_data;
            if (op.start_tx) begin
                obuf <= ac_byte;
                pend <= 1'b1;
                busy <= 1'b0;
            end else if (tx_valid && tx_ready) begin
                pend <= 1'b0;
                busy <= 1'b1;
                cnt  <= tx_delay;
            end else if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/mtio_ctrl.sv
// Multi-line terminal IOT controller top. Decodes each IOT, answers it,
// routes the resulting action to one line and ORs the summary interrupts.
// Assumes line_count in 1..MAXL and MAXL <= 16.
module mtio_ctrl #(
    parameter int MAXL  = 16,
    parameter int BW    = 8,
    parameter int DLY_W = 8,
    localparam int LW   = (MAXL > 1) ? $clog2(MAXL) : 1,
    localparam int CW   = $clog2(MAXL + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           line_count,
    input  logic [DLY_W-1:0]        tx_delay,
    input  logic                    iot_valid,
    input  logic [8:0]              iot_code,
    input  logic [mtio_pkg::AW-1:0] iot_ac,
    output logic                    iot_skip,
    output logic [mtio_pkg::AW-1:0] iot_ac_out,
    output logic                    iot_nomatch,
    output logic                    iot_illegal,
    output logic                    irq_in,
    output logic                    irq_out,
    input  logic [MAXL-1:0]         rx_valid,
    input  logic [MAXL*BW-1:0]      rx_data,
    input  logic [MAXL-1:0]         rx_break,
    output logic [MAXL-1:0]         rx_ready,
    output logic [MAXL-1:0]         tx_valid,
    output logic [MAXL*BW-1:0]      tx_data,
    input  logic [MAXL-1:0]         tx_ready
);
    import mtio_pkg::*;

    logic            hit;
    logic            is_out;
    logic [LW-1:0]   sel_line;
    line_op_t        op;
    logic [MAXL-1:0] idone, odone, en;
    logic [MAXL-1:0] act, act_q;
    logic [BW-1:0]   rbuf [MAXL];
    line_op_t        op_l [MAXL];

    mtio_decode #(.MAXL(MAXL), .LW(LW), .CW(CW)) u_decode (
        .dev    (iot_code[8:3]),
        .count  (line_count),
        .hit    (hit),
        .line   (sel_line),
        .is_out (is_out)
    );

    mtio_respond #(.BW(BW)) u_respond (
        .valid     (iot_valid),
        .hit       (hit),
        .is_out    (is_out),
        .pulse     (iot_code[2:0]),
        .ac        (iot_ac),
        .sel_idone (idone[sel_line]),
        .sel_odone (odone[sel_line]),
        .sel_en    (en[sel_line]),
        .sel_rbuf  (rbuf[sel_line]),
        .skip      (iot_skip),
        .ac_out    (iot_ac_out),
        .nomatch   (iot_nomatch),
        .illegal   (iot_illegal),
        .op        (op)
    );

    // Remember which lines were in service last cycle
    always_ff @(posedge clk) begin
        act_q <= act;
    end

    for (genvar i = 0; i < MAXL; i++) begin : g_line
        assign act[i]  = int'(line_count) > i;
        assign op_l[i] = (sel_line == LW'(i)) ? op : '0;

        mtio_line #(.BW(BW), .DLY_W(DLY_W)) u_line (
            .clk      (clk),
            .wipe     (!rst_n || (act[i] != act_q[i])),
            .live     (act[i] & act_q[i]),
            .op       (op_l[i]),
            .ac_byte  (iot_ac[BW-1:0]),
            .rx_valid (rx_valid[i]),
            .rx_data  (rx_data[i*BW +: BW]),
            .rx_break (rx_break[i]),
            .rx_ready (rx_ready[i]),
            .tx_valid (tx_valid[i]),
            .tx_data  (tx_data[i*BW +: BW]),
            .tx_ready (tx_ready[i]),
            .tx_delay (tx_delay),
            .idone    (idone[i]),
            .odone    (odone[i]),
            .en       (en[i]),
            .rbuf     (rbuf[i])
        );
    end

    assign irq_in  = |(idone & en);
    assign irq_out = |(odone & en);

endmodule

// File: rtl/mtio_ctrl_chk.sv
// Protocol checker for mtio_ctrl, attached by bind. Observes ports only.
module mtio_ctrl_chk #(
    parameter int MAXL = 16,
    parameter int CW   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CW-1:0]           line_count,
    input logic                    iot_valid,
    input logic [mtio_pkg::AW-1:0] iot_ac,
    input logic                    iot_skip,
    input logic [mtio_pkg::AW-1:0] iot_ac_out,
    input logic                    iot_nomatch,
    input logic                    iot_illegal,
    input logic [MAXL-1:0]         rx_valid,
    input logic [MAXL-1:0]         rx_ready,
    input logic [MAXL-1:0]         tx_valid,
    input logic [MAXL-1:0]         tx_ready
);
    // No response without a strobe
    assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !iot_valid |-> (!iot_skip && !iot_nomatch && !iot_illegal));

    // Unclaimed device passes AC through without skip
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iot_valid && iot_nomatch) |-> (iot_ac_out == iot_ac && !iot_skip));

    // Illegal pulse passes AC and excludes the no-match report
    assert_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        iot_illegal |-> (iot_ac_out == iot_ac && $onehot0({iot_nomatch, iot_illegal})));

    for (genvar i = 0; i < MAXL; i++) begin : g_chk
        // An accepted character blocks the port until it is read
        assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[i] && rx_ready[i]) |=> !rx_ready[i]);

        // A waiting transmit stays offered unless an IOT or count change intervenes
        assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid[i] && !tx_ready[i] && !iot_valid)
            |=> (tx_valid[i] || line_count != $past(line_count)));

        // Lines out of service keep both ports quiet
        assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(line_count) <= i && int'($past(line_count)) <= i)
            |-> (!tx_valid[i] && !rx_ready[i]));
    end

endmodule

bind mtio_ctrl mtio_ctrl_chk #(.MAXL(MAXL), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_count  (line_count),
    .iot_valid   (iot_valid),
    .iot_ac      (iot_ac),
    .iot_skip    (iot_skip),
    .iot_ac_out  (iot_ac_out),
    .iot_nomatch (iot_nomatch),
    .iot_illegal (iot_illegal),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready)
);

// File: tb/mtio_ctrl_tb.sv
`timescale 1ns/1ps
module mtio_ctrl_tb;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [4:0]    line_count;
    logic [7:0]    tx_delay;
    logic          iot_valid;
    logic [8:0]    iot_code;
    logic [11:0]   iot_ac;
    logic          iot_skip, iot_nomatch, iot_illegal, irq_in, irq_out;
    logic [11:0]   iot_ac_out;
    logic [N-1:0]  rx_valid, rx_break, rx_ready, tx_valid, tx_ready;
    logic [N*8-1:0] rx_data, tx_data;

    always #2.5 clk = ~clk;

    mtio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_count(line_count), .tx_delay(tx_delay),
        .iot_valid(iot_valid), .iot_code(iot_code), .iot_ac(iot_ac),
        .iot_skip(iot_skip), .iot_ac_out(iot_ac_out), .iot_nomatch(iot_nomatch),
        .iot_illegal(iot_illegal), .irq_in(irq_in), .irq_out(irq_out),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model state
    int tab [32] = '{'o40,'o41,'o42,'o43,'o44,'o45,'o46,'o47,'o34,'o35,'o11,'o12,
                     'o30,'o31,'o32,'o33,'o50,'o51,'o52,'o53,'o54,'o55,'o56,'o57,
                     'o70,'o71,'o36,'o37,'o72,'o73,'o06,'o07};
    int m_id[N], m_od[N], m_en[N], m_rb[N], m_ob[N];
    int m_pend[N], m_busy[N], m_cnt[N], m_actq[N];
    int e_skip, e_ac, e_nom, e_ill, e_hit, e_ln, e_dir, e_pulse;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected combinational responses from the requirements
    task automatic model_eval();
        int dev;
        dev = int'(iot_code[8:3]);
        e_pulse = int'(iot_code[2:0]);
        e_hit = 0; e_ln = 0; e_dir = 0;
        for (int k = 0; k < 2 * int'(line_count); k++) begin
            if (e_hit == 0 && tab[k] == dev) begin
                e_hit = 1; e_ln = k / 2; e_dir = k % 2;
            end
        end
        e_skip = 0; e_ac = int'(iot_ac); e_nom = 0; e_ill = 0;
        if (iot_valid) begin
            if (e_hit == 0) e_nom = 1;
            else if (e_dir == 0) begin
                case (e_pulse)
                    0, 5: ;
                    1: e_skip = m_id[e_ln];
                    2: e_ac = 0;
                    6: e_ac = m_rb[e_ln];
                    default: e_ill = 1;
                endcase
            end else begin
                case (e_pulse)
                    0, 2, 4, 6: ;
                    1: e_skip = m_od[e_ln];
                    5: e_skip = (m_en[e_ln] != 0 && (m_id[e_ln] != 0 || m_od[e_ln] != 0)) ? 1 : 0;
                    default: e_ill = 1;
                endcase
            end
        end
    endtask

    task automatic wipe_line(input int i, input int a);
        m_id[i] = 0; m_od[i] = 0; m_en[i] = 1; m_rb[i] = 0; m_ob[i] = 0;
        m_pend[i] = 0; m_busy[i] = 0; m_cnt[i] = 0; m_actq[i] = a;
    endtask

    // Advance the model one clock edge
    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            int a, live, sel, acc, sent, cin, sout, cout, st;
            a = (i < int'(line_count)) ? 1 : 0;
            if (!rst_n || a != m_actq[i]) begin
                wipe_line(i, a);
                continue;
            end
            live = a;
            sel  = (iot_valid && e_hit != 0 && e_ln == i) ? 1 : 0;
            cin = 0; sout = 0; cout = 0; st = 0;
            if (sel != 0 && e_dir == 0) begin
                if (e_pulse == 0 || e_pulse == 2 || e_pulse == 6) cin = 1;
                if (e_pulse == 5) m_en[i] = iot_ac[0];
            end
            if (sel != 0 && e_dir == 1) begin
                if (e_pulse == 0) sout = 1;
                if (e_pulse == 2 || e_pulse == 6) cout = 1;
                if (e_pulse == 4 || e_pulse == 6) st = 1;
            end
            acc = (live != 0 && rx_valid[i] && m_id[i] == 0) ? 1 : 0;
            sent = 0;
            if (st != 0) begin
                m_ob[i] = int'(iot_ac[7:0]); m_pend[i] = 1; m_busy[i] = 0;
            end else if (m_pend[i] != 0 && tx_ready[i]) begin
                m_pend[i] = 0; m_busy[i] = 1; m_cnt[i] = int'(tx_delay);
            end else if (m_busy[i] != 0) begin
                if (m_cnt[i] == 0) begin m_busy[i] = 0; sent = 1; end
                else m_cnt[i]--;
            end
            if (cout != 0) m_od[i] = 0;
            if (sout != 0 || sent != 0) m_od[i] = 1;
            if (cin != 0) m_id[i] = 0;
            if (acc != 0) begin
                m_id[i] = 1;
                m_rb[i] = rx_break[i] ? 0 : int'(rx_data[i*8 +: 8]);
            end
        end
    endtask

    // One clock: compare every output at the falling edge, then step model
    task automatic cyc();
        @(negedge clk);
        model_eval();
        if (rst_n) begin
            int ii, io, live;
            chk(int'(iot_skip), e_skip, "R3 skip");
            chk(int'(iot_ac_out), e_ac, "R12 ac_out");
            chk(int'(iot_nomatch), e_nom, "R2 nomatch");
            chk(int'(iot_illegal), e_ill, "R11 illegal");
            ii = 0; io = 0;
            for (int i = 0; i < N; i++) begin
                live = (i < int'(line_count) && m_actq[i] != 0) ? 1 : 0;
                if (m_id[i] != 0 && m_en[i] != 0) ii = 1;
                if (m_od[i] != 0 && m_en[i] != 0) io = 1;
                chk(int'(rx_ready[i]), (live != 0 && m_id[i] == 0) ? 1 : 0, "R7 rx_ready");
                chk(int'(tx_valid[i]), (live != 0 && m_pend[i] != 0) ? 1 : 0, "R6 tx_valid");
                if (tx_valid[i]) chk(int'(tx_data[i*8 +: 8]), m_ob[i], "R6 tx_data");
            end
            chk(int'(irq_in), ii, "R8 irq_in");
            chk(int'(irq_out), io, "R8 irq_out");
        end
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic iot(input int dev, input int pulse, input int ac);
        iot_valid = 1'b1;
        iot_code  = {6'(dev), 3'(pulse)};
        iot_ac    = 12'(ac);
        #1;
    endtask

    task automatic idle();
        iot_valid = 1'b0;
        iot_code  = '0;
        iot_ac    = '0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; line_count = 5'd4; tx_delay = 8'd3;
        rx_valid = '0; rx_break = '0; rx_data = '0; tx_ready = '0;
        idle();
        cyc(); cyc();
        rst_n = 1'b1;
        #1;
        chk(int'(rx_ready[3:0]), 'hF, "R9 reset rx_ready");
        chk(int'(irq_in | irq_out), 0, "R9 reset irq");
        cyc();

        // R9: enable is set after reset; R5 set/skip/clear
        iot('o41, 5, 0); chk(int'(iot_skip), 0, "R4 no flag"); cyc();
        iot('o41, 0, 0); cyc();
        iot('o41, 5, 0); chk(int'(iot_skip), 1, "R9 enable after reset");
        chk(int'(irq_out), 1, "R8 irq_out"); cyc();
        iot('o43, 1, 0); chk(int'(iot_skip), 0, "R1 other line"); cyc();
        iot('o41, 1, 0); chk(int'(iot_skip), 1, "R5 skip set"); cyc();
        iot('o41, 2, 0); cyc();
        iot('o41, 1, 0); chk(int'(iot_skip), 0, "R5 cleared"); cyc();

        // R7/R3 receive on line 1
        idle(); rx_valid[1] = 1'b1; rx_data[15:8] = 8'h41; #1;
        chk(int'(rx_ready[1]), 1, "R7 ready"); cyc();
        rx_data[15:8] = 8'h99; #1;
        chk(int'(rx_ready[1]), 0, "R7 held off"); cyc();
        rx_valid[1] = 1'b0;
        iot('o42, 1, 0); chk(int'(iot_skip), 1, "R3 input done"); cyc();
        iot('o42, 6, 'o7777); chk(int'(iot_ac_out), 'h041, "R3 read byte"); cyc();
        iot('o42, 1, 0); chk(int'(iot_skip), 0, "R3 cleared by read"); cyc();

        // R7 break on line 2
        idle(); rx_valid[2] = 1'b1; rx_break[2] = 1'b1; rx_data[23:16] = 8'h55; cyc();
        rx_valid[2] = 1'b0; rx_break[2] = 1'b0;
        iot('o44, 6, 'hFFF); chk(int'(iot_ac_out), 0, "R7 break stores 0"); cyc();
        iot('o44, 2, 'h123); chk(int'(iot_ac_out), 0, "R3 clear AC"); cyc();

        // R4 shared enable
        iot('o40, 5, 0); cyc();
        iot('o41, 0, 0); cyc();
        iot('o41, 5, 0); chk(int'(iot_skip), 0, "R4 disabled");
        chk(int'(irq_out), 0, "R8 masked"); cyc();
        iot('o40, 5, 1); cyc();
        iot('o41, 5, 0); chk(int'(iot_skip), 1, "R4 enabled"); cyc();

        // R2 unclaimed then claimed after raising count
        iot('o34, 1, 'o1234); chk(int'(iot_nomatch), 1, "R2 nomatch");
        chk(int'(iot_ac_out), 'o1234, "R2 pass AC"); cyc();
        idle(); line_count = 5'd16; cyc(); cyc();
        iot('o34, 0, 0); chk(int'(iot_nomatch), 0, "R2 claimed"); cyc();

        // R6 transmit on line 5 (011/012)
        iot('o12, 6, 'h1C3); cyc();
        idle(); #1;
        chk(int'(tx_valid[5]), 1, "R6 offered");
        chk(int'(tx_data[47:40]), 'hC3, "R6 byte"); cyc(); cyc();
        tx_ready[5] = 1'b1; cyc();
        tx_ready[5] = 1'b0; cyc(); cyc(); cyc();
        iot('o12, 1, 0); chk(int'(iot_skip), 0, "R6 not yet done"); cyc();
        iot('o12, 1, 0); chk(int'(iot_skip), 1, "R6 done after delay"); cyc();
        iot('o12, 4, 'h07E); cyc();
        iot('o12, 1, 0); chk(int'(iot_skip), 1, "R6 pulse 4 keeps flag"); cyc();
        idle(); tx_ready[5] = 1'b1; tx_delay = 8'd0; cyc(); tx_ready[5] = 1'b0;
        cyc(); cyc();

        // R11 illegal pulses
        iot('o40, 3, 'o5555); chk(int'(iot_illegal), 1, "R11 input 3");
        chk(int'(iot_ac_out), 'o5555, "R11 pass AC"); cyc();
        iot('o41, 7, 0); chk(int'(iot_illegal), 1, "R11 output 7"); cyc();

        // R1 last line
        iot('o07, 0, 0); cyc();
        iot('o07, 1, 0); chk(int'(iot_skip), 1, "R1 line 15"); cyc();

        // R10 remove and re-add line 3 (046/047)
        iot('o47, 0, 0); cyc();
        iot('o46, 5, 0); cyc();
        idle(); line_count = 5'd2; cyc(); cyc();
        iot('o46, 1, 0); chk(int'(iot_nomatch), 1, "R10 removed line"); cyc();
        idle(); line_count = 5'd4; cyc(); cyc();
        iot('o47, 1, 0); chk(int'(iot_skip), 0, "R10 flag cleared"); cyc();
        iot('o47, 0, 0); cyc();
        iot('o47, 5, 0); chk(int'(iot_skip), 1, "R10 enable set"); cyc();

        // R9 reset cancels a transmit
        iot('o41, 6, 'h5A); cyc();
        idle(); rst_n = 1'b0; cyc();
        rst_n = 1'b1; #1;
        chk(int'(tx_valid[0]), 0, "R9 transmit cancelled");
        cyc();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule